// File: doc/BRIEF.md
# Register Altered Trap Tracker

This block follows the architectural state changes made while one instruction runs and keeps a single "state was altered" flag. Store ports of main memory, the fast register file and status-word fields report their writes as one-cycle strobes. A condition-code write counts only when the running instruction also reads the condition codes as inputs. When a trap is signalled, the block captures the current status doubleword into a saved image. The live flag goes into bit 60 of that image, and the flag then clears. Trap handlers use that bit to decide whether the faulting instruction can be retried without side effects.

The block also holds the status doubleword. A doubleword load arrives in two halves. The first half waits in a staging register and is committed, together with the second half, only when the second half arrives without a fault. A fault on the second half, or a trap taken before it arrives, throws the staged half away and leaves the status doubleword and the altered flag untouched. Detecting the trap cause and sequencing the status save are handled elsewhere.

Top module: `reg_altered_tracker`

## Requirements
- R1: After reset, `altered` is 0 and both `psw_out` and `saved_psw` are all zeros.
- R2: A strobe on `mem_wr`, `freg_wr` or `sw_wr` makes `altered` read 1 from the next cycle, unless a trap is taken in the same cycle.
- R3: A strobe on `cc_wr` sets `altered` only when `cc_used` is 1 in the same cycle. With `cc_used` at 0 it leaves `altered` unchanged.
- R4: `instr_start` clears `altered` for the next cycle. If an alteration event comes in the same cycle, that event belongs to the new instruction and `altered` reads 1.
- R5: On `trap`, `saved_psw` loads the status doubleword as it stands after that cycle's update. Bit 60 of the image (counting from bit 0 = LSB) is overridden with `altered` OR-ed with any alteration event in that same cycle.
- R6: The cycle after a trap, `altered` reads 0, even when `instr_start` or an alteration event comes with the trap.
- R7: `psw_ld_first` alone changes neither `psw_out` nor `altered`. The word is only staged.
- R8: `psw_ld_second` without `psw_second_fault`, while a first half is staged, commits {first half in bits 63:32, second half in bits 31:0} to `psw_out` and sets `altered`.
- R9: `psw_second_fault` throws away the staged half, leaving `psw_out` and `altered` unchanged. A later `psw_ld_second` that has no new first half does nothing.
- R10: A trap throws away a staged first half that has not been committed. A second half that arrives afterwards does not change `psw_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_start | input | 1 | First cycle of a new instruction |
| mem_wr | input | 1 | Main memory store strobe |
| freg_wr | input | 1 | Fast register write strobe |
| sw_wr | input | 1 | Status-word field or flag write strobe |
| cc_wr | input | 1 | Condition-code write strobe |
| cc_used | input | 1 | Current instruction reads the condition codes |
| psw_ld_first | input | 1 | First half of a status doubleword load is valid |
| psw_first_word | input | 32 | First half (upper word) |
| psw_ld_second | input | 1 | Second half has been fetched |
| psw_second_word | input | 32 | Second half (lower word) |
| psw_second_fault | input | 1 | Second-half fetch faulted |
| trap | input | 1 | Trap taken this cycle |
| altered | output | 1 | Live altered flag |
| psw_out | output | 64 | Committed status doubleword |
| saved_psw | output | 64 | Status image captured on the last trap, with the altered bit at 60 |

## Verification
The closest interaction is between a trap and a status-doubleword commit, or any other alteration event, in the same cycle. The trap has to take the image after the commit and set bit 60 from that cycle's event, while the live flag still clears. The bench raises `trap` in the same cycle as a successful second half, and in the same cycle as a memory store. It then compares the whole captured image against a doubleword built from the written halves with bit 60 forced to 1, and checks that `altered` reads 0 one cycle later. A trap that arrives between the two halves is checked separately, to confirm that the late second half is discarded.

// File: rtl/ralt_pkg.sv
package ralt_pkg;

  // True when any source in this cycle changes architectural state.
  function automatic logic alter_event(
    input logic mem,
    input logic freg,
    input logic sw,
    input logic cc,
    input logic cc_use,
    input logic commit
  );
    return mem | freg | sw | (cc & cc_use) | commit;
  endfunction

  // Next flag value: a trap clears it; a start restarts it from this cycle's event.
  function automatic logic next_flag(
    input logic cur,
    input logic ev,
    input logic start,
    input logic trp
  );
    if (trp)        return 1'b0;
    else if (start) return ev;
    else            return cur | ev;
  endfunction

endpackage

// File: rtl/ralt_stage.sv
module ralt_stage #(
  parameter int PSW_W = 64,
  localparam int HALF = PSW_W / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_first,
  input  logic [HALF-1:0]  first_word,
  input  logic             ld_second,
  input  logic [HALF-1:0]  second_word,
  input  logic             second_fault,
  input  logic             trap,
  output logic             commit,
  output logic [PSW_W-1:0] psw_next,
  output logic [PSW_W-1:0] psw_q
);
  logic [HALF-1:0] stage_q;
  logic            stage_v;

  assign commit   = ld_second & ~second_fault & stage_v;
  assign psw_next = commit ? {stage_q, second_word} : psw_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
      stage_v <= 1'b0;
      psw_q   <= '0;
    end else begin
      psw_q <= psw_next;
      if (trap) begin
        stage_v <= 1'b0;
      end else if (ld_first) begin
        stage_q <= first_word;
        stage_v <= 1'b1;
      end else if (ld_second || second_fault) begin
        stage_v <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ralt_accum.sv
module ralt_accum
  import ralt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic instr_start,
  input  logic mem_wr,
  input  logic freg_wr,
  input  logic sw_wr,
  input  logic cc_wr,
  input  logic cc_used,
  input  logic commit,
  input  logic trap,
  output logic any_event,
  output logic flag_q
);
  assign any_event = alter_event(mem_wr, freg_wr, sw_wr, cc_wr, cc_used, commit);

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= next_flag(flag_q, any_event, instr_start, trap);
  end
endmodule

// File: rtl/ralt_capture.sv
module ralt_capture #(
  parameter int PSW_W   = 64,
  parameter int ALT_BIT = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trap,
  input  logic [PSW_W-1:0] psw_next,
  input  logic             alt_bit,
  output logic [PSW_W-1:0] saved_q
);
  logic [PSW_W-1:0] image;

  always_comb begin
    image          = psw_next;
    image[ALT_BIT] = alt_bit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    saved_q <= '0;
    else if (trap) saved_q <= image;
  end
endmodule

// File: rtl/reg_altered_tracker.sv
module reg_altered_tracker #(
  parameter int PSW_W   = 64,
  parameter int ALT_BIT = 60,
  localparam int HALF   = PSW_W / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_start,
  input  logic             mem_wr,
  input  logic             freg_wr,
  input  logic             sw_wr,
  input  logic             cc_wr,
  input  logic             cc_used,
  input  logic             psw_ld_first,
  input  logic [HALF-1:0]  psw_first_word,
  input  logic             psw_ld_second,
  input  logic [HALF-1:0]  psw_second_word,
  input  logic             psw_second_fault,
  input  logic             trap,
  output logic             altered,
  output logic [PSW_W-1:0] psw_out,
  output logic [PSW_W-1:0] saved_psw
);
  logic             commit;
  logic             any_event;
  logic [PSW_W-1:0] psw_next;

  ralt_stage #(.PSW_W(PSW_W)) u_stage (
    .clk, .rst_n,
    .ld_first(psw_ld_first), .first_word(psw_first_word),
    .ld_second(psw_ld_second), .second_word(psw_second_word),
    .second_fault(psw_second_fault), .trap,
    .commit, .psw_next, .psw_q(psw_out)
  );

  ralt_accum u_accum (
    .clk, .rst_n, .instr_start, .mem_wr, .freg_wr, .sw_wr,
    .cc_wr, .cc_used, .commit, .trap, .any_event, .flag_q(altered)
  );

  ralt_capture #(.PSW_W(PSW_W), .ALT_BIT(ALT_BIT)) u_capture (
    .clk, .rst_n, .trap, .psw_next,
    .alt_bit(altered | any_event), .saved_q(saved_psw)
  );
endmodule

// File: rtl/ralt_checker.sv
module ralt_checker #(
  parameter int PSW_W   = 64,
  parameter int ALT_BIT = 60
) (
  input logic             clk,
  input logic             rst_n,
  input logic             instr_start,
  input logic             mem_wr,
  input logic             freg_wr,
  input logic             sw_wr,
  input logic             cc_wr,
  input logic             cc_used,
  input logic             trap,
  input logic             commit,
  input logic             any_event,
  input logic             altered,
  input logic [PSW_W-1:0] psw_out,
  input logic [PSW_W-1:0] saved_psw
);
  // R2
  a_r2_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_wr || freg_wr || sw_wr) && !trap) |=> altered);
  // R3
  a_r3_cc_unused_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_wr && !cc_used && !mem_wr && !freg_wr && !sw_wr && !commit && !altered) |=> !altered);
  // R4
  a_r4_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_start && !any_event) |=> !altered);
  // R5
  a_r5_alt_bit_saved: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> saved_psw[ALT_BIT] == $past(altered || any_event));
  // R6
  a_r6_trap_clears: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> !altered);
  // R7
  a_r7_psw_held: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(psw_out));
  // R8
  a_r8_commit_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !trap) |=> altered);
endmodule

bind reg_altered_tracker ralt_checker #(.PSW_W(PSW_W), .ALT_BIT(ALT_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_start(instr_start), .mem_wr(mem_wr),
  .freg_wr(freg_wr), .sw_wr(sw_wr), .cc_wr(cc_wr), .cc_used(cc_used),
  .trap(trap), .commit(commit), .any_event(any_event), .altered(altered),
  .psw_out(psw_out), .saved_psw(saved_psw)
);

// File: tb/reg_altered_tracker_tb.sv
module reg_altered_tracker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_start = 0, mem_wr = 0, freg_wr = 0, sw_wr = 0;
  logic        cc_wr = 0, cc_used = 0, psw_ld_first = 0, psw_ld_second = 0;
  logic        psw_second_fault = 0, trap = 0;
  logic [31:0] psw_first_word = '0, psw_second_word = '0;
  logic        altered;
  logic [63:0] psw_out, saved_psw;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  reg_altered_tracker u_dut (.*);

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    {instr_start, mem_wr, freg_wr, sw_wr, cc_wr, cc_used} = '0;
    {psw_ld_first, psw_ld_second, psw_second_fault, trap} = '0;
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] stamp(logic [63:0] v, logic b);
    logic [63:0] r = v;
    r[60] = b;
    return r;
  endfunction

  task automatic begin_instr();
    idle(); instr_start = 1; tick(); idle();
  endtask

  task automatic t_reset();
    chk("R1 altered", altered, 0);
    chk("R1 psw_out", psw_out, 0);
    chk("R1 saved_psw", saved_psw, 0);
  endtask

  task automatic t_direct();
    for (int k = 0; k < 3; k++) begin
      begin_instr();
      chk("R4 clear", altered, 0);
      mem_wr = (k == 0); freg_wr = (k == 1); sw_wr = (k == 2);
      tick(); idle();
      chk("R2 write sets", altered, 1);
    end
  endtask

  task automatic t_cc();
    begin_instr();
    cc_wr = 1; cc_used = 0; tick(); idle();
    chk("R3 cc unused", altered, 0);
    cc_wr = 1; cc_used = 1; tick(); idle();
    chk("R3 cc used", altered, 1);
  endtask

  task automatic t_start();
    mem_wr = 1; tick(); idle();
    instr_start = 1; tick(); idle();
    chk("R4 start alone", altered, 0);
    mem_wr = 1; tick(); idle();
    instr_start = 1; freg_wr = 1; tick(); idle();
    chk("R4 start with event", altered, 1);
  endtask

  task automatic t_load();
    begin_instr();
    psw_ld_first = 1; psw_first_word = 32'h1234_5678; tick(); idle();
    chk("R7 psw held", psw_out, 0);
    chk("R7 altered", altered, 0);
    psw_ld_second = 1; psw_second_word = 32'h9abc_def0; tick(); idle();
    chk("R8 commit", psw_out, 64'h1234_5678_9abc_def0);
    chk("R8 altered", altered, 1);
  endtask

  task automatic t_fault();
    begin_instr();
    psw_ld_first = 1; psw_first_word = 32'hdead_beef; tick(); idle();
    psw_ld_second = 1; psw_second_fault = 1; psw_second_word = 32'h1111_2222; tick(); idle();
    chk("R9 psw kept", psw_out, 64'h1234_5678_9abc_def0);
    chk("R9 altered", altered, 0);
    psw_ld_second = 1; psw_second_word = 32'h3333_4444; tick(); idle();
    chk("R9 stray second", psw_out, 64'h1234_5678_9abc_def0);
  endtask

  task automatic t_trap();
    begin_instr();
    mem_wr = 1; tick(); idle();
    trap = 1; tick(); idle();
    chk("R5 image set", saved_psw, stamp(64'h1234_5678_9abc_def0, 1));
    chk("R6 cleared", altered, 0);
    begin_instr();
    trap = 1; tick(); idle();
    chk("R5 image clear", saved_psw, stamp(64'h1234_5678_9abc_def0, 0));
    trap = 1; mem_wr = 1; instr_start = 1; tick(); idle();
    chk("R5 same-cycle event", saved_psw, stamp(64'h1234_5678_9abc_def0, 1));
    chk("R6 cleared with event", altered, 0);
  endtask

  task automatic t_trap_stage();
    begin_instr();
    psw_ld_first = 1; psw_first_word = 32'h5555_aaaa; tick(); idle();
    trap = 1; tick(); idle();
    psw_ld_second = 1; psw_second_word = 32'h7777_8888; tick(); idle();
    chk("R10 stage dropped", psw_out, 64'h1234_5678_9abc_def0);
    chk("R10 altered", altered, 0);
  endtask

  task automatic t_overlap();
    begin_instr();
    psw_ld_first = 1; psw_first_word = 32'h0fed_cba9; tick(); idle();
    psw_ld_second = 1; psw_second_word = 32'h8765_4321; trap = 1; tick(); idle();
    chk("R8 commit with trap", psw_out, 64'h0fed_cba9_8765_4321);
    chk("R5 image after commit", saved_psw, stamp(64'h0fed_cba9_8765_4321, 1));
    chk("R6 cleared after commit", altered, 0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    t_reset();
    rst_n = 1;
    tick();
    t_direct();
    t_cc();
    t_start();
    t_load();
    t_fault();
    t_trap();
    t_trap_stage();
    t_overlap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule